// File: doc/BRIEF.md
# DMA Dispatcher Status and Control Register Block

This block is the software-facing register file of a descriptor-driven DMA dispatcher. It sits beside the descriptor FIFO, the response FIFO and the data engines, none of which it contains. Live flags from those units (engine busy, FIFO empty and full) and their fill levels and sequence numbers can be read through a simple word-addressed register port. Engine events (an error, an early termination, a completion that requests an interrupt) are captured in sticky status flags.

Software programs a control word. That word drives a stop output, a stop-descriptor-fetch output, the stop policies for errors and early terminations, and a global interrupt enable. A software reset runs for a fixed number of cycles. While it runs, the resetting status bit is high, the engine reset output is asserted, and all sticky state is cleared. When the count ends, the reset request bit clears itself. The single interrupt output is the pending interrupt flag gated by the global enable. Software clears the flag by writing one to it.

Top module: `dispatch_csr`

## Requirements
- R1: After a synchronous reset, the control word reads 0, every sticky status bit (5 to 9) reads 0, and irq, stop_out, sw_reset_out and stop_fetch_out are all 0.
- R2: Control register (address 0x04) bits: 0 stop, 1 reset request, 2 stop on error, 3 stop on early termination, 4 global interrupt enable, 5 stop descriptor fetch. Bits 0 and 2 to 5 hold the last written value and read back unchanged. Bits 31:6 read 0.
- R3: Address 0x08 reads {wr_fill, rd_fill}, address 0x0C reads {16'b0, resp_fill} and address 0x10 reads {wr_seq, rd_seq}. Writes to these addresses have no effect.
- R4: Status register (address 0x00) bits 0 to 4 show eng_busy, desc_empty, desc_full, resp_empty and resp_full live. Writing ones to bits 0 to 6 changes nothing.
- R5: An ev_error pulse while control bit 2 is set makes status bits 7 and 5 read 1, and stop_out is asserted one cycle later. With control bit 2 clear, the pulse is ignored.
- R6: An ev_early pulse while control bit 3 is set makes status bits 8 and 5 read 1. With control bit 3 clear, the pulse is ignored.
- R7: An ev_done_irq pulse sets status bit 9. The irq output equals status bit 9 ANDed with control bit 4.
- R8: Writing 1 to status bits 7, 8 or 9 clears those bits. Writing 0 leaves them unchanged, and writing 0x3FF clears all three. If an event sets a bit in the same cycle that software clears it, the set wins.
- R9: Writing control bit 1 starts a reset. For exactly RST_CYCLES cycles, status bit 6, control bit 1 and sw_reset_out read 1, then they drop. The reset clears the sticky bits, and events that arrive during it are ignored.
- R10: stop_out and status bit 5 are 1 when control bit 0, status bit 7 or status bit 8 is set. stop_fetch_out follows control bit 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 5 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| eng_busy | input | 1 | Data engines busy |
| desc_empty | input | 1 | Descriptor FIFO empty |
| desc_full | input | 1 | Descriptor FIFO full |
| resp_empty | input | 1 | Response FIFO empty |
| resp_full | input | 1 | Response FIFO full |
| wr_fill | input | 16 | Write descriptor FIFO fill level |
| rd_fill | input | 16 | Read descriptor FIFO fill level |
| resp_fill | input | 16 | Response FIFO fill level |
| wr_seq | input | 16 | Write engine sequence number |
| rd_seq | input | 16 | Read engine sequence number |
| ev_error | input | 1 | Error event pulse |
| ev_early | input | 1 | Early-termination event pulse |
| ev_done_irq | input | 1 | Completion event with interrupt requested |
| irq | output | 1 | Interrupt request |
| stop_out | output | 1 | Stop request to the engines |
| sw_reset_out | output | 1 | Engine and FIFO reset while the reset sequence runs |
| stop_fetch_out | output | 1 | Halt descriptor fetching |

## Verification
The assertions assume that the event inputs are single-cycle pulses sampled on the clock, and that only one register write happens per cycle. They also assume that a control write carrying the reset bit meets either an idle reset counter or one already running, and that the running count is never restarted. The stimulus drives every input on the falling edge, pulses each event for one cycle, and issues one write at a time. During the reset window it writes nothing to the control register, so the reset length property sees only clean windows.

// File: rtl/dispatch_csr_pkg.sv
package dispatch_csr_pkg;

    localparam int unsigned ADDR_W = 5;
    localparam int unsigned DATA_W = 32;
    localparam int unsigned HALF_W = DATA_W / 2;

    localparam logic [ADDR_W-1:0] A_STATUS = 5'h00;
    localparam logic [ADDR_W-1:0] A_CTRL   = 5'h04;
    localparam logic [ADDR_W-1:0] A_FILL   = 5'h08;
    localparam logic [ADDR_W-1:0] A_RFILL  = 5'h0C;
    localparam logic [ADDR_W-1:0] A_SEQ    = 5'h10;

    // Packed so that halt lands on bit 0 of the control word.
    typedef struct packed {
        logic halt_desc;      // bit 5
        logic irq_en;         // bit 4
        logic halt_on_early;  // bit 3
        logic halt_on_err;    // bit 2
        logic soft_rst;       // bit 1 (reads as reset in progress)
        logic halt;           // bit 0
    } ctrl_t;

    // Sticky flags, bit order matches status bits 9:7.
    typedef struct packed {
        logic irq;
        logic early_stop;
        logic err_stop;
    } sticky_t;

    typedef struct packed {
        logic resp_full;
        logic resp_empty;
        logic desc_full;
        logic desc_empty;
        logic busy;
    } live_t;

    function automatic logic [DATA_W-1:0] status_word(
        input live_t   lv,
        input logic    stopped,
        input logic    resetting,
        input sticky_t st
    );
        logic [DATA_W-1:0] w;
        w      = '0;
        w[4:0] = lv;
        w[5]   = stopped;
        w[6]   = resetting;
        w[9:7] = st;
        return w;
    endfunction

endpackage

// File: rtl/dcsr_ctrl_reg.sv
module dcsr_ctrl_reg
    import dispatch_csr_pkg::*;
#(
    parameter int unsigned RST_CYCLES = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_ctrl,
    input  logic [5:0] wdata,
    output ctrl_t      ctrl,
    output logic       resetting
);
    localparam int unsigned CNT_W = $clog2(RST_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(RST_CYCLES);

    logic [CNT_W-1:0] cnt_q;
    logic             halt_q, err_q, early_q, ien_q, hdesc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            halt_q  <= 1'b0;
            err_q   <= 1'b0;
            early_q <= 1'b0;
            ien_q   <= 1'b0;
            hdesc_q <= 1'b0;
            cnt_q   <= '0;
        end else begin
            if (wr_ctrl) begin
                halt_q  <= wdata[0];
                err_q   <= wdata[2];
                early_q <= wdata[3];
                ien_q   <= wdata[4];
                hdesc_q <= wdata[5];
            end
            if (wr_ctrl && wdata[1] && (cnt_q == '0))
                cnt_q <= CNT_LOAD;
            else if (cnt_q != '0)
                cnt_q <= cnt_q - 1'b1;
        end
    end

    assign resetting = (cnt_q != '0);

    always_comb begin
        ctrl.halt          = halt_q;
        ctrl.soft_rst      = resetting;
        ctrl.halt_on_err   = err_q;
        ctrl.halt_on_early = early_q;
        ctrl.irq_en        = ien_q;
        ctrl.halt_desc     = hdesc_q;
    end

endmodule

// File: rtl/dcsr_sticky.sv
module dcsr_sticky
    import dispatch_csr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       resetting,
    input  logic [2:0] w1c,
    input  logic       ev_error,
    input  logic       ev_early,
    input  logic       ev_done_irq,
    input  logic       err_en,
    input  logic       early_en,
    output sticky_t    flags
);
    logic [2:0] set_v;
    logic [2:0] q;

    assign set_v = {ev_done_irq, ev_early & early_en, ev_error & err_en};

    for (genvar i = 0; i < 3; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst || resetting)
                q[i] <= 1'b0;
            else
                q[i] <= (q[i] & ~w1c[i]) | set_v[i];
        end
    end

    assign flags = sticky_t'(q);

endmodule

// File: rtl/dcsr_rdmux.sv
module dcsr_rdmux
    import dispatch_csr_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] status_w,
    input  ctrl_t             ctrl,
    input  logic [HALF_W-1:0] wr_fill,
    input  logic [HALF_W-1:0] rd_fill,
    input  logic [HALF_W-1:0] resp_fill,
    input  logic [HALF_W-1:0] wr_seq,
    input  logic [HALF_W-1:0] rd_seq,
    output logic [DATA_W-1:0] rdata
);
    always_comb begin
        unique case (addr)
            A_STATUS: rdata = status_w;
            A_CTRL:   rdata = DATA_W'(ctrl);
            A_FILL:   rdata = {wr_fill, rd_fill};
            A_RFILL:  rdata = {{HALF_W{1'b0}}, resp_fill};
            A_SEQ:    rdata = {wr_seq, rd_seq};
            default:  rdata = '0;
        endcase
    end

endmodule

// File: rtl/dispatch_csr.sv
module dispatch_csr
    import dispatch_csr_pkg::*;
#(
    parameter int unsigned RST_CYCLES = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_wr,
    input  logic [4:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic        eng_busy,
    input  logic        desc_empty,
    input  logic        desc_full,
    input  logic        resp_empty,
    input  logic        resp_full,
    input  logic [15:0] wr_fill,
    input  logic [15:0] rd_fill,
    input  logic [15:0] resp_fill,
    input  logic [15:0] wr_seq,
    input  logic [15:0] rd_seq,
    input  logic        ev_error,
    input  logic        ev_early,
    input  logic        ev_done_irq,
    output logic        irq,
    output logic        stop_out,
    output logic        sw_reset_out,
    output logic        stop_fetch_out
);
    ctrl_t   ctrl;
    sticky_t flags;
    live_t   live;
    logic    resetting;
    logic    stopped;
    logic    wr_ctrl, wr_stat;
    logic    unused_wbits;

    assign wr_ctrl      = bus_wr && (bus_addr == A_CTRL);
    assign wr_stat      = bus_wr && (bus_addr == A_STATUS);
    assign unused_wbits = ^{bus_wdata[31:10], bus_wdata[6]};

    dcsr_ctrl_reg #(.RST_CYCLES(RST_CYCLES)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .wr_ctrl   (wr_ctrl),
        .wdata     (bus_wdata[5:0]),
        .ctrl      (ctrl),
        .resetting (resetting)
    );

    dcsr_sticky u_sticky (
        .clk         (clk),
        .rst         (rst),
        .resetting   (resetting),
        .w1c         (wr_stat ? bus_wdata[9:7] : 3'b000),
        .ev_error    (ev_error),
        .ev_early    (ev_early),
        .ev_done_irq (ev_done_irq),
        .err_en      (ctrl.halt_on_err),
        .early_en    (ctrl.halt_on_early),
        .flags       (flags)
    );

    assign live    = '{resp_full: resp_full, resp_empty: resp_empty,
                       desc_full: desc_full, desc_empty: desc_empty,
                       busy: eng_busy};
    assign stopped = ctrl.halt | flags.err_stop | flags.early_stop;

    dcsr_rdmux u_rdmux (
        .addr      (bus_addr),
        .status_w  (status_word(live, stopped, resetting, flags)),
        .ctrl      (ctrl),
        .wr_fill   (wr_fill),
        .rd_fill   (rd_fill),
        .resp_fill (resp_fill),
        .wr_seq    (wr_seq),
        .rd_seq    (rd_seq),
        .rdata     (bus_rdata)
    );

    assign irq            = ctrl.irq_en & flags.irq;
    assign stop_out       = stopped;
    assign sw_reset_out   = resetting;
    assign stop_fetch_out = ctrl.halt_desc;

endmodule

// File: rtl/dispatch_csr_chk.sv
module dispatch_csr_chk
    import dispatch_csr_pkg::*;
#(
    parameter int unsigned RST_CYCLES = 8
) (
    input logic       clk,
    input logic       rst,
    input logic       bus_wr,
    input logic [4:0] bus_addr,
    input logic       wd_rst,
    input logic       wd_irq,
    input logic       ev_error,
    input logic       ev_done_irq,
    input ctrl_t      ctrl_bits,
    input logic       irq,
    input logic       stop_out,
    input logic       sw_reset_out
);
    localparam int unsigned RUN_W = $clog2(RST_CYCLES + 2);

    logic [RUN_W-1:0] run_cnt;
    logic             ctrl_wr;

    assign ctrl_wr = bus_wr && (bus_addr == A_CTRL);

    always_ff @(posedge clk) begin
        if (rst || !sw_reset_out)
            run_cnt <= '0;
        else
            run_cnt <= run_cnt + 1'b1;
    end

    // R1
    rst_quiet_chk: assert property (@(posedge clk)
        rst |=> (!irq && !stop_out && !sw_reset_out));

    // R9
    reset_start_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && wd_rst) |=> sw_reset_out);

    // R9
    reset_len_chk: assert property (@(posedge clk) disable iff (rst)
        run_cnt <= RUN_W'(RST_CYCLES));

    // R5
    err_stop_chk: assert property (@(posedge clk) disable iff (rst)
        (ev_error && ctrl_bits.halt_on_err && !sw_reset_out) |=> stop_out);

    // R7
    irq_set_chk: assert property (@(posedge clk) disable iff (rst)
        (ev_done_irq && ctrl_bits.irq_en && !sw_reset_out && !ctrl_wr) |=> irq);

    // R8
    irq_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == A_STATUS && wd_irq && !ev_done_irq) |=> !irq);

endmodule

bind dispatch_csr dispatch_csr_chk #(.RST_CYCLES(RST_CYCLES)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .bus_wr       (bus_wr),
    .bus_addr     (bus_addr),
    .wd_rst       (bus_wdata[1]),
    .wd_irq       (bus_wdata[9]),
    .ev_error     (ev_error),
    .ev_done_irq  (ev_done_irq),
    .ctrl_bits    (ctrl),
    .irq          (irq),
    .stop_out     (stop_out),
    .sw_reset_out (sw_reset_out)
);

// File: tb/dispatch_csr_bench.sv
module dispatch_csr_bench;

    localparam int RST_CYCLES = 8;
    localparam logic [31:0] LIVE = 32'h0000_000D; // busy=1,dempty=0,dfull=1,rempty=1,rfull=0

    typedef struct packed {
        logic [3:0]  req;
        logic        wr;
        logic [4:0]  addr;
        logic [31:0] wdata;
        logic [2:0]  ev;     // {error, early, done_irq}
        logic [4:0]  caddr;
        logic [31:0] exp;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t TBL [NV] = '{
        '{4'd2,  1'b1, 5'h04, 32'h0000_003D, 3'b000, 5'h04, 32'h0000_003D}, // R2
        '{4'd2,  1'b1, 5'h04, 32'hFFFF_FFDC, 3'b000, 5'h04, 32'h0000_001C}, // R2 upper bits
        '{4'd3,  1'b1, 5'h08, 32'hFFFF_FFFF, 3'b000, 5'h08, 32'h0012_0034}, // R3
        '{4'd3,  1'b0, 5'h0C, 32'h0000_0000, 3'b000, 5'h0C, 32'h0000_0056}, // R3
        '{4'd3,  1'b1, 5'h10, 32'h0000_0000, 3'b000, 5'h10, 32'h0789_0ABC}, // R3
        '{4'd4,  1'b1, 5'h00, 32'h0000_007F, 3'b000, 5'h00, LIVE},          // R4
        '{4'd5,  1'b0, 5'h00, 32'h0000_0000, 3'b100, 5'h00, 32'h0000_00AD}, // R5
        '{4'd8,  1'b1, 5'h00, 32'h0000_0080, 3'b000, 5'h00, LIVE},          // R8
        '{4'd6,  1'b0, 5'h00, 32'h0000_0000, 3'b010, 5'h00, 32'h0000_012D}, // R6
        '{4'd7,  1'b0, 5'h00, 32'h0000_0000, 3'b001, 5'h00, 32'h0000_032D}, // R7
        '{4'd8,  1'b1, 5'h00, 32'h0000_0200, 3'b000, 5'h00, 32'h0000_012D}, // R8
        '{4'd8,  1'b1, 5'h00, 32'h0000_0000, 3'b000, 5'h00, 32'h0000_012D}, // R8 zero write
        '{4'd8,  1'b1, 5'h00, 32'h0000_03FF, 3'b000, 5'h00, LIVE},          // R8 clear all
        '{4'd2,  1'b1, 5'h04, 32'h0000_0010, 3'b000, 5'h04, 32'h0000_0010}, // R2
        '{4'd5,  1'b0, 5'h00, 32'h0000_0000, 3'b110, 5'h00, LIVE},          // R5 R6 policy off
        '{4'd10, 1'b1, 5'h04, 32'h0000_0001, 3'b000, 5'h00, 32'h0000_002D}, // R10
        '{4'd10, 1'b1, 5'h04, 32'h0000_0020, 3'b000, 5'h04, 32'h0000_0020}  // R10
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        ev_error = 1'b0, ev_early = 1'b0, ev_done_irq = 1'b0;
    logic        irq, stop_out, sw_reset_out, stop_fetch_out;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    dispatch_csr #(.RST_CYCLES(RST_CYCLES)) u_dispatch_csr (
        .clk(clk), .rst(rst),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .eng_busy(1'b1), .desc_empty(1'b0), .desc_full(1'b1),
        .resp_empty(1'b1), .resp_full(1'b0),
        .wr_fill(16'h0012), .rd_fill(16'h0034), .resp_fill(16'h0056),
        .wr_seq(16'h0789), .rd_seq(16'h0ABC),
        .ev_error(ev_error), .ev_early(ev_early), .ev_done_irq(ev_done_irq),
        .irq(irq), .stop_out(stop_out), .sw_reset_out(sw_reset_out),
        .stop_fetch_out(stop_fetch_out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // called on a falling edge; returns on the next falling edge
    task automatic step(input logic w, input logic [4:0] a, input logic [31:0] d,
                        input logic [2:0] ev);
        bus_wr = w; bus_addr = a; bus_wdata = d;
        {ev_error, ev_early, ev_done_irq} = ev;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
        {ev_error, ev_early, ev_done_irq} = 3'b000;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    initial begin
        #(8 * 100000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(5'h04, v); chk("R1 ctrl", v, 32'h0);
        rd(5'h00, v); chk("R1 status", v, LIVE);
        chk("R1 outputs", {28'h0, irq, stop_out, sw_reset_out, stop_fetch_out}, 32'h0);

        // table walk
        for (int i = 0; i < NV; i++) begin
            step(TBL[i].wr, TBL[i].addr, TBL[i].wdata, TBL[i].ev);
            rd(TBL[i].caddr, v);
            chk($sformatf("R%0d vec%0d", TBL[i].req, i), v, TBL[i].exp);
        end

        // R10 fetch halt and stop output
        chk("R10 stop_fetch", {31'h0, stop_fetch_out}, 32'h1);
        chk("R10 no stop", {31'h0, stop_out}, 32'h0);
        step(1'b1, 5'h04, 32'h11, 3'b000);
        chk("R10 stop on halt", {31'h0, stop_out}, 32'h1);
        step(1'b1, 5'h04, 32'h10, 3'b000);
        chk("R10 stop released", {31'h0, stop_out}, 32'h0);

        // R7 interrupt gating
        step(1'b0, 5'h00, 32'h0, 3'b001);
        chk("R7 irq enabled", {31'h0, irq}, 32'h1);
        step(1'b1, 5'h04, 32'h00, 3'b000);
        chk("R7 irq gated", {31'h0, irq}, 32'h0);
        rd(5'h00, v); chk("R7 pending kept", v, 32'h20D);

        // R8 set wins over clear
        step(1'b1, 5'h04, 32'h10, 3'b000);
        step(1'b1, 5'h00, 32'h200, 3'b001);
        chk("R8 set wins", {31'h0, irq}, 32'h1);
        step(1'b1, 5'h00, 32'h200, 3'b000);
        chk("R8 irq cleared", {31'h0, irq}, 32'h0);

        // R5 stop on error and its release
        step(1'b1, 5'h04, 32'h04, 3'b000);
        step(1'b0, 5'h00, 32'h0, 3'b100);
        chk("R5 stop_out", {31'h0, stop_out}, 32'h1);
        rd(5'h00, v); chk("R5 status", v, 32'hAD);
        step(1'b1, 5'h00, 32'h80, 3'b000);
        chk("R5 released", {31'h0, stop_out}, 32'h0);

        // R9 reset handshake
        step(1'b0, 5'h00, 32'h0, 3'b101);
        step(1'b1, 5'h04, 32'h06, 3'b000);
        for (int c = 1; c <= RST_CYCLES; c++) begin
            chk($sformatf("R9 active c%0d", c), {31'h0, sw_reset_out}, 32'h1);
            if (c == 1) begin
                rd(5'h00, v); chk("R9 status bit6", v & 32'h40, 32'h40);
                rd(5'h04, v); chk("R9 ctrl bit1", v & 32'h2, 32'h2);
            end
            if (c < RST_CYCLES)
                step(1'b0, 5'h00, 32'h0, (c == 3) ? 3'b111 : 3'b000);
        end
        step(1'b0, 5'h00, 32'h0, 3'b000);
        chk("R9 done", {31'h0, sw_reset_out}, 32'h0);
        rd(5'h00, v); chk("R9 sticky cleared", v, LIVE);
        rd(5'h04, v); chk("R9 ctrl self-clear", v, 32'h04);
        chk("R9 stop and irq low", {30'h0, stop_out, irq}, 32'h0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule